// File: doc/BRIEF.md
# Data Cache Tag Directory

This block is a set-associative tag directory. It tracks which memory blocks a data cache would hold, but it stores no data. Its purpose is to measure hit and miss behaviour for a chosen cache geometry. Each access brings a byte address and a read/write flag. The directory looks the tag up in the addressed set and reports a hit or a miss one cycle later, together with the way it used. It then updates the per-way usage counters of that set. On a miss it installs the new tag in a victim way. Four free-running 32-bit event counters record read hits, read misses, write hits and write misses.

Alongside direct accesses, five command registers accept an address from the surrounding logic:

| Command | Action |
|---|---|
| Prefetch | Looks the address up as a read |
| Flush | Invalidates the matching block |
| Invalidate | Invalidates the matching block |
| Writeback | Clears its register only |
| Lock | Clears its register only |

A register holding a nonzero address is serviced when the directory is idle and then clears itself.

A way-enable mask limits which ways may be chosen as victims and which ways may be invalidated. The number of sets, the block size, the number of ways, the number of usage states and the address width are all parameters.

Top module: `dcache_tag_dir`

## Requirements
- R1: For an address A, the set is (A / BLOCK_BYTES) mod SETS and the tag is (A / BLOCK_BYTES) / SETS. BLOCK_BYTES and SETS are powers of two, and SETS is at least 2.
- R2: An access with accValid=1 is looked up only when cachePresent=1 and cacheEnable=1. Otherwise rspValid stays 0 on the next cycle and no event counter changes.
- R3: A looked-up access gives rspValid=1 on the following cycle, with rspHit, rspWay and rspWrite (the access's write flag). When several ways hold the tag, rspWay is the highest-numbered matching way.
- R4: On a miss, the victim is the highest-numbered way whose usage counter is below USTATES-1 and whose wayEnable bit is set. If no way qualifies, way 0 is the victim. The victim receives the new tag and is reported in rspWay.
- R5: On every lookup, the selected way's usage counter is set to USTATES-1. Every other way of that set with a nonzero counter decrements by one.
- R6: Read hits, read misses, write hits and write misses each have their own 32-bit counter, which wraps on overflow. Each response increments exactly one of them.
- R7: An invalidate requires only cachePresent=1. If the address hits a way whose wayEnable bit is set, that way's tag becomes all ones. On a miss, or when that way's enable bit is clear, nothing changes.
- R8: The command registers are written with cmdWe=1, with cmdSel selecting the register: 0 prefetch, 1 flush, 2 invalidate, 3 writeback, 4 lock. cmdPending bit i is 1 while register i is nonzero. A serviced register is cleared. Prefetch acts as a read lookup (gated as in R2). Flush and invalidate each perform R7. Writeback and lock only clear. cmdSel values 5 to 7 are ignored.
- R9: While accValid=1, no command register is serviced. Otherwise exactly one pending register is serviced per cycle, the lowest-numbered first. A write to a register in the cycle it is serviced keeps the written value.
- R10: After reset, all tags are all ones, all usage counters and event counters are zero, cmdPending is zero and rspValid is 0.
- R11: There is no separate valid bit. After reset, an address whose tag is all ones hits, and it hits in the highest-numbered way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cachePresent | input | 1 | Directory present; gates all operations |
| cacheEnable | input | 1 | Cache enabled; gates lookups |
| wayEnable | input | WAYS | Ways allowed for replacement and invalidation |
| accValid | input | 1 | Access strobe |
| accWrite | input | 1 | 1 = write access, 0 = read access |
| accAddr | input | ADDR_W | Access byte address |
| cmdWe | input | 1 | Command register write strobe |
| cmdSel | input | 3 | Command register select |
| cmdWdata | input | ADDR_W | Address written to the command register |
| cmdPending | output | 5 | Nonzero flag for each command register |
| rspValid | output | 1 | Lookup result valid |
| rspHit | output | 1 | Lookup hit |
| rspWrite | output | 1 | Write flag of the reported lookup |
| rspWay | output | WAY_W | Way hit or replaced |
| rdHitCnt | output | 32 | Read hit count |
| rdMissCnt | output | 32 | Read miss count |
| wrHitCnt | output | 32 | Write hit count |
| wrMissCnt | output | 32 | Write miss count |

## Verification
The random part of the bench draws addresses from a handful of tags per set. This makes hits, misses and evictions all common, and the way-enable mask changes now and then. As a result, a wrong victim choice or a wrong usage counter update shows up as a later hit/miss mismatch. Directed patterns cover the following cases:
- An all-ones tag right after reset, which separates a design with no valid bit from one that has a valid bit.
- Disabled accesses, which separate correct gating from counting.
- Commands queued behind a held access, which show the service order.
- An invalidate on a way whose enable bit is clear, which must be left intact.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  localparam int NUM_CMD      = 5;
  localparam int CMD_PREFETCH = 0;
  localparam int CMD_FLUSH    = 1;
  localparam int CMD_INVAL    = 2;
  localparam int CMD_WBACK    = 3;
  localparam int CMD_LOCK     = 4;

  // Strobes from control to the directory datapath
  typedef struct packed {
    logic lookup;
    logic inval;
    logic write;
  } dirOp_t;
endpackage

// File: rtl/dcd_ctrl.sv
module dcd_ctrl #(
  parameter int ADDR_W = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cachePresent,
  input  logic                        cacheEnable,
  input  logic                        accValid,
  input  logic                        accWrite,
  input  logic [ADDR_W-1:0]           accAddr,
  input  logic                        cmdWe,
  input  logic [2:0]                  cmdSel,
  input  logic [ADDR_W-1:0]           cmdWdata,
  output dcd_pkg::dirOp_t             op,
  output logic [ADDR_W-1:0]           opAddr,
  output logic [dcd_pkg::NUM_CMD-1:0] cmdPending
);
  import dcd_pkg::*;

  logic [ADDR_W-1:0]  cmdReg [NUM_CMD];
  logic [NUM_CMD-1:0] grant;
  logic [ADDR_W-1:0]  grantAddr;

  for (genvar i = 0; i < NUM_CMD; i++) begin : g_pend
    assign cmdPending[i] = |cmdReg[i];
  end

  // Lowest-numbered pending register wins, only when no access holds the slot
  always_comb begin
    grant = '0;
    grantAddr = '0;
    if (!accValid) begin
      for (int i = NUM_CMD - 1; i >= 0; i--) begin
        if (cmdPending[i]) begin
          grant = '0;
          grant[i] = 1'b1;
          grantAddr = cmdReg[i];
        end
      end
    end
  end

  always_comb begin
    op = '0;
    opAddr = accAddr;
    if (accValid) begin
      op.lookup = cachePresent && cacheEnable;
      op.write = accWrite;
    end else begin
      opAddr = grantAddr;
      op.lookup = grant[CMD_PREFETCH] && cachePresent && cacheEnable;
      op.inval = (grant[CMD_FLUSH] || grant[CMD_INVAL]) && cachePresent;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_CMD; i++) begin
      if (!rstN) cmdReg[i] <= '0;
      else if (cmdWe && cmdSel == 3'(i)) cmdReg[i] <= cmdWdata;
      else if (grant[i]) cmdReg[i] <= '0;
    end
  end
endmodule

// File: rtl/dcd_datapath.sv
module dcd_datapath #(
  parameter int ADDR_W      = 32,
  parameter int SETS        = 512,
  parameter int BLOCK_BYTES = 16,
  parameter int WAYS        = 1,
  parameter int USTATES     = 2,
  localparam int OFF_W = $clog2(BLOCK_BYTES),
  localparam int SET_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - OFF_W - SET_W,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int USE_W = $clog2(USTATES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dcd_pkg::dirOp_t   op,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [WAYS-1:0]   wayEnable,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspWrite,
  output logic [WAY_W-1:0]  rspWay,
  output logic [31:0]       rdHitCnt,
  output logic [31:0]       rdMissCnt,
  output logic [31:0]       wrHitCnt,
  output logic [31:0]       wrMissCnt
);
  localparam logic [USE_W-1:0] MAX_USE = USE_W'(USTATES - 1);

  logic [TAG_W-1:0] tagMem [SETS][WAYS];
  logic [USE_W-1:0] useMem [SETS][WAYS];

  logic [SET_W-1:0] setIdx;
  logic [TAG_W-1:0] reqTag;
  logic             hitAny;
  logic [WAY_W-1:0] hitWay, victim, selWay;

  assign setIdx = opAddr[OFF_W +: SET_W];
  assign reqTag = opAddr[ADDR_W-1 -: TAG_W];

  // Highest matching way and highest eligible victim
  always_comb begin
    hitAny = 1'b0;
    hitWay = '0;
    victim = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (tagMem[setIdx][w] == reqTag) begin
        hitAny = 1'b1;
        hitWay = WAY_W'(w);
      end
      if (useMem[setIdx][w] < MAX_USE && wayEnable[w]) victim = WAY_W'(w);
    end
    selWay = hitAny ? hitWay : victim;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          tagMem[s][w] <= '1;
          useMem[s][w] <= '0;
        end
      rspValid <= 1'b0;
      rspHit <= 1'b0;
      rspWrite <= 1'b0;
      rspWay <= '0;
      rdHitCnt <= '0;
      rdMissCnt <= '0;
      wrHitCnt <= '0;
      wrMissCnt <= '0;
    end else begin
      rspValid <= op.lookup;
      if (op.lookup) begin
        rspHit <= hitAny;
        rspWay <= selWay;
        rspWrite <= op.write;
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == selWay) useMem[setIdx][w] <= MAX_USE;
          else if (useMem[setIdx][w] != '0) useMem[setIdx][w] <= useMem[setIdx][w] - 1'b1;
        end
        tagMem[setIdx][selWay] <= reqTag;
        case ({op.write, hitAny})
          2'b01:   rdHitCnt <= rdHitCnt + 32'd1;
          2'b00:   rdMissCnt <= rdMissCnt + 32'd1;
          2'b11:   wrHitCnt <= wrHitCnt + 32'd1;
          default: wrMissCnt <= wrMissCnt + 32'd1;
        endcase
      end else if (op.inval && hitAny && wayEnable[hitWay]) begin
        tagMem[setIdx][hitWay] <= '1;
      end
    end
  end
endmodule

// File: rtl/dcache_tag_dir.sv
module dcache_tag_dir #(
  parameter int ADDR_W      = 32,
  parameter int SETS        = 512,
  parameter int BLOCK_BYTES = 16,
  parameter int WAYS        = 1,
  parameter int USTATES     = 2,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cachePresent,
  input  logic              cacheEnable,
  input  logic [WAYS-1:0]   wayEnable,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              cmdWe,
  input  logic [2:0]        cmdSel,
  input  logic [ADDR_W-1:0] cmdWdata,
  output logic [4:0]        cmdPending,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspWrite,
  output logic [WAY_W-1:0]  rspWay,
  output logic [31:0]       rdHitCnt,
  output logic [31:0]       rdMissCnt,
  output logic [31:0]       wrHitCnt,
  output logic [31:0]       wrMissCnt
);
  dcd_pkg::dirOp_t   op;
  logic [ADDR_W-1:0] opAddr;

  dcd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cachePresent(cachePresent), .cacheEnable(cacheEnable),
    .accValid(accValid), .accWrite(accWrite), .accAddr(accAddr),
    .cmdWe(cmdWe), .cmdSel(cmdSel), .cmdWdata(cmdWdata),
    .op(op), .opAddr(opAddr), .cmdPending(cmdPending)
  );

  dcd_datapath #(
    .ADDR_W(ADDR_W), .SETS(SETS), .BLOCK_BYTES(BLOCK_BYTES),
    .WAYS(WAYS), .USTATES(USTATES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .op(op), .opAddr(opAddr), .wayEnable(wayEnable),
    .rspValid(rspValid), .rspHit(rspHit), .rspWrite(rspWrite), .rspWay(rspWay),
    .rdHitCnt(rdHitCnt), .rdMissCnt(rdMissCnt), .wrHitCnt(wrHitCnt), .wrMissCnt(wrMissCnt)
  );
endmodule

// File: rtl/dcd_checker.sv
module dcd_checker #(
  parameter int ADDR_W = 32,
  parameter int WAYS   = 1,
  parameter int WAY_W  = 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             cachePresent,
  input logic             cacheEnable,
  input logic             accValid,
  input logic             accWrite,
  input logic             cmdWe,
  input logic [2:0]       cmdSel,
  input logic [4:0]       cmdPending,
  input logic             rspValid,
  input logic             rspWrite,
  input logic [WAY_W-1:0] rspWay,
  input logic [31:0]      rdHitCnt,
  input logic [31:0]      rdMissCnt,
  input logic [31:0]      wrHitCnt,
  input logic [31:0]      wrMissCnt
);
  logic [31:0] evSum;
  assign evSum = rdHitCnt + rdMissCnt + wrHitCnt + wrMissCnt;

  assert_gate_R2: assert property (@(posedge clk) disable iff (!rstN)
    !cachePresent |=> !rspValid);

  assert_lookup_R3: assert property (@(posedge clk) disable iff (!rstN)
    accValid && cachePresent && cacheEnable |=> rspValid && rspWrite == $past(accWrite));

  assert_way_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> int'(rspWay) < WAYS);

  assert_one_count_R6: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> evSum == $past(evSum) + 32'd1);

  assert_no_count_R6: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> evSum == $past(evSum));

  assert_prefetch_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmdPending[0] && !accValid && !(cmdWe && cmdSel == 3'd0) |=> !cmdPending[0]);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    accValid && !cmdWe |=> cmdPending == $past(cmdPending));
endmodule

bind dcache_tag_dir dcd_checker #(.ADDR_W(ADDR_W), .WAYS(WAYS), .WAY_W(WAY_W)) u_chk (
  .clk(clk), .rstN(rstN), .cachePresent(cachePresent), .cacheEnable(cacheEnable),
  .accValid(accValid), .accWrite(accWrite), .cmdWe(cmdWe), .cmdSel(cmdSel),
  .cmdPending(cmdPending), .rspValid(rspValid), .rspWrite(rspWrite), .rspWay(rspWay),
  .rdHitCnt(rdHitCnt), .rdMissCnt(rdMissCnt), .wrHitCnt(wrHitCnt), .wrMissCnt(wrMissCnt)
);

// File: tb/sim_dcache_tag_dir.sv
`timescale 1ns/1ps
module sim_dcache_tag_dir;
  localparam int AW = 12, NS = 8, BB = 16, NW = 4, NU = 4;
  localparam int TAGW = AW - 4 - 3;
  localparam int ONES = (1 << TAGW) - 1;

  logic clk = 1'b0, rstN = 1'b0;
  logic cachePresent = 1'b1, cacheEnable = 1'b1;
  logic [NW-1:0] wayEn = '1;
  logic accValid = 1'b0, accWrite = 1'b0;
  logic [AW-1:0] accAddr = '0;
  logic cmdWe = 1'b0;
  logic [2:0] cmdSel = '0;
  logic [AW-1:0] cmdWdata = '0;
  logic [4:0] cmdPending;
  logic rspValid, rspHit, rspWrite;
  logic [1:0] rspWay;
  logic [31:0] rdHitCnt, rdMissCnt, wrHitCnt, wrMissCnt;

  always #4 clk = ~clk;

  dcache_tag_dir #(.ADDR_W(AW), .SETS(NS), .BLOCK_BYTES(BB), .WAYS(NW), .USTATES(NU)) u0 (
    .clk(clk), .rstN(rstN), .cachePresent(cachePresent), .cacheEnable(cacheEnable),
    .wayEnable(wayEn), .accValid(accValid), .accWrite(accWrite), .accAddr(accAddr),
    .cmdWe(cmdWe), .cmdSel(cmdSel), .cmdWdata(cmdWdata), .cmdPending(cmdPending),
    .rspValid(rspValid), .rspHit(rspHit), .rspWrite(rspWrite), .rspWay(rspWay),
    .rdHitCnt(rdHitCnt), .rdMissCnt(rdMissCnt), .wrHitCnt(wrHitCnt), .wrMissCnt(wrMissCnt)
  );

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;
  int mTag [NS][NW];
  int mUse [NS][NW];
  int eRh = 0, eRm = 0, eWh = 0, eWm = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R1 mapping, R4 victim, R5 usage update
  function automatic void mLookup(input bit wr, input int addr, output bit h, output int way);
    int s, t, vic;
    s = (addr / BB) % NS;
    t = (addr / BB) / NS;
    h = 0; way = 0; vic = 0;
    for (int w = 0; w < NW; w++) begin
      if (mTag[s][w] == t) begin h = 1; way = w; end
      if (mUse[s][w] < NU - 1 && wayEn[w]) vic = w;
    end
    if (!h) way = vic;
    mTag[s][way] = t;
    for (int w = 0; w < NW; w++)
      if (w == way) mUse[s][w] = NU - 1;
      else if (mUse[s][w] > 0) mUse[s][w]--;
    if (wr) begin if (h) eWh++; else eWm++; end
    else begin if (h) eRh++; else eRm++; end
  endfunction

  function automatic void mInval(input int addr);
    int s, t, hw;
    bit h;
    s = (addr / BB) % NS;
    t = (addr / BB) / NS;
    h = 0; hw = 0;
    for (int w = 0; w < NW; w++) if (mTag[s][w] == t) begin h = 1; hw = w; end
    if (h && wayEn[hw]) mTag[s][hw] = ONES;
  endfunction

  task automatic chkCounts(input string req);
    chk(rdHitCnt == 32'(eRh) && rdMissCnt == 32'(eRm) && wrHitCnt == 32'(eWh) && wrMissCnt == 32'(eWm),
        req, {rdHitCnt[15:0], rdMissCnt[15:0], wrHitCnt[15:0], wrMissCnt[15:0]},
        {16'(eRh), 16'(eRm), 16'(eWh), 16'(eWm)});
  endtask

  // Called at a negedge; returns at the negedge where the response is visible
  task automatic doAcc(input bit wr, input int addr, input string req);
    bit h, live;
    int way;
    live = cachePresent && cacheEnable;
    if (live) mLookup(wr, addr, h, way);
    accValid = 1'b1; accWrite = wr; accAddr = AW'(addr);
    @(negedge clk);
    accValid = 1'b0;
    if (live) begin
      chk(rspValid && rspHit == h && int'(rspWay) == way && rspWrite == wr, req,
          {rspValid, rspHit, rspWrite, rspWay}, {1'b1, h, wr, 2'(way)});
    end else begin
      chk(!rspValid, req, rspValid, 0);
    end
    chkCounts(req);
  endtask

  task automatic wrCmd(input int sel, input int addr);
    cmdWe = 1'b1; cmdSel = 3'(sel); cmdWdata = AW'(addr);
    @(negedge clk);
    cmdWe = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd7);
    for (int s = 0; s < NS; s++) for (int w = 0; w < NW; w++) begin mTag[s][w] = ONES; mUse[s][w] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!rspValid && cmdPending == 0, "R10", {rspValid, cmdPending}, 0);
    chkCounts("R10");

    // R11: all-ones tag hits right after reset, highest way (R3)
    doAcc(1'b0, (ONES * NS + 7) * BB + 3, "R11");
    doAcc(1'b1, 12'h123, "R4");
    doAcc(1'b1, 12'h123, "R3");

    // R2 gating
    cacheEnable = 1'b0;
    doAcc(1'b0, 12'h040, "R2");
    cacheEnable = 1'b1; cachePresent = 1'b0;
    doAcc(1'b1, 12'h040, "R2");
    cachePresent = 1'b1;

    // R4 with a restricted mask: only way 1 may be replaced
    wayEn = 4'b0010;
    doAcc(1'b0, 12'h210, "R4");
    doAcc(1'b0, 12'h410, "R4");
    doAcc(1'b0, 12'h210, "R5");
    wayEn = 4'b0000;
    doAcc(1'b0, 12'h610, "R4");
    wayEn = '1;

    // R8 prefetch acts as a read: written, serviced next cycle, response after
    begin
      bit h; int way;
      mLookup(1'b0, 12'h350, h, way);
      wrCmd(0, 12'h350);
      @(negedge clk);
      chk(rspValid && !rspWrite && rspHit == h && int'(rspWay) == way && cmdPending == 0, "R8",
          {rspValid, rspWrite, rspHit, rspWay, cmdPending}, {1'b1, 1'b0, h, 2'(way), 5'd0});
      chkCounts("R8");
    end

    // R7: invalidate via command, with the way enabled
    doAcc(1'b0, 12'h550, "R7");
    mInval(12'h550);
    wrCmd(2, 12'h550);
    @(negedge clk);
    chk(!rspValid && cmdPending == 0, "R7", {rspValid, cmdPending}, 0);
    doAcc(1'b0, 12'h550, "R7");
    // R7: flush on a way whose enable bit is clear leaves it
    wayEn = 4'b0000;
    mInval(12'h550);
    wrCmd(1, 12'h550);
    @(negedge clk);
    wayEn = '1;
    doAcc(1'b0, 12'h550, "R7");

    // R8 writeback only clears
    wrCmd(3, 12'h700);
    chk(cmdPending == 5'b01000, "R8", cmdPending, 5'b01000);
    @(negedge clk);
    chk(cmdPending == 0 && !rspValid, "R8", {rspValid, cmdPending}, 0);
    chkCounts("R8");
    // R8 select 5 ignored
    wrCmd(5, 12'h700);
    chk(cmdPending == 0, "R8", cmdPending, 0);

    // R9: commands wait behind a held access, then lowest first one per cycle
    cmdWe = 1'b1; cmdSel = 3'd4; cmdWdata = 12'h111;
    @(negedge clk);
    cmdSel = 3'd3; cmdWdata = 12'h222;
    accValid = 1'b1; accWrite = 1'b0; accAddr = 12'h0A0;
    begin bit h; int way; mLookup(1'b0, 12'h0A0, h, way); mLookup(1'b0, 12'h0A0, h, way); end
    @(negedge clk);
    cmdWe = 1'b0;
    @(negedge clk);
    chk(cmdPending == 5'b11000, "R9", cmdPending, 5'b11000);
    accValid = 1'b0;
    @(negedge clk);
    chk(cmdPending == 5'b10000, "R9", cmdPending, 5'b10000);
    chkCounts("R9");
    // R9: rewrite lock in the cycle it is serviced keeps new value
    wrCmd(4, 12'h333);
    chk(cmdPending == 5'b10000, "R9", cmdPending, 5'b10000);
    @(negedge clk);
    chk(cmdPending == 0, "R9", cmdPending, 0);

    // Random accesses (R1, R3, R4, R5, R6)
    for (int n = 0; n < 600; n++) begin
      int t, s, a;
      if ($urandom_range(0, 19) == 0) wayEn = NW'($urandom_range(0, 15));
      t = ($urandom_range(0, 7) == 0) ? ONES : $urandom_range(0, 5);
      s = $urandom_range(0, 2);
      a = (t * NS + s) * BB + $urandom_range(0, 15);
      doAcc(1'($urandom_range(0, 1)), a, "R6");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule